// File: doc/BRIEF.md
# Firmware Hub Single-Byte Read Target

This block is a bus target for a 4-bit multiplexed firmware-hub bus. It answers one kind of transaction: a single-byte memory read. On every rising clock edge it samples a frame strobe (active low) and the nibble bus. It then walks a fixed sequence of fields: the opening code, a device select, seven address nibbles, a size nibble and two turnaround clocks. When the select nibble equals the value on its ID strap and the size is one byte, the target takes the bus. It drives a ready sync nibble, then the two halves of the data byte, then an all-ones turnaround nibble, and then releases the bus.

The nibble bus is split into an input, an output and an output enable, so a pad ring or a bench can resolve the shared wires. Data comes from a synchronous memory read port. The target presents the low address bits with a one-clock read strobe and expects the byte on the clock after. A full cycle lasts 17 clocks, counted from the clock that carries the opening code. The host takes the bus back on the 17th clock. Another cycle may start on the clock after that.

Top module: `fwh_read_target`

## Requirements
- R1: A cycle begins only on a clock where `frameN` is low and `busIn` equals 4'b1101. Any other nibble under a low strobe, or 4'b1101 under a high strobe, starts nothing. Starting nothing means `busOe` and `memRdEn` stay low.
- R2: The strobe may stay low for several clocks. In that case the opening code is the nibble sampled on the last clock with the strobe low. If that nibble is not 4'b1101, the target does not respond, even when earlier low-strobe clocks carried 4'b1101.
- R3: The nibble on the clock after the opening code is the device select. If it differs from `idStrap`, the target never drives the bus and never reads memory until the next opening code.
- R4: Clocks 3 to 9 carry a 28-bit address, most-significant nibble first. `memAddr` equals the low ADDR_W bits of that address while `memRdEn` is high.
- R5: `memRdEn` is high for exactly one clock, clock 11 of an accepted cycle. That is two clocks before the target first drives the bus.
- R6: Clock 10 carries the size nibble. If it is not 4'b0000, the cycle is dropped: no read is issued and the bus is never driven.
- R7: `busOe` is low during both turnaround clocks 11 and 12. On clock 13, `busOe` is high and `busOut` is 4'b0000, the ready sync.
- R8: The low nibble of the memory byte is on `busOut` on clock 14. The high nibble is on `busOut` on clock 15.
- R9: On clock 16, `busOut` is 4'b1111 with `busOe` high. `busOe` is low from clock 17 on, so it is high for exactly four consecutive clocks per cycle.
- R10: While `rstN` is low, the target is idle with `busOe` and `memRdEn` low. This holds even when reset lands in the middle of a data phase.
- R11: A new opening code on the clock right after clock 17 starts a new cycle that is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all fields are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| frameN | input | 1 | Active-low frame strobe from the host |
| busIn | input | 4 | Nibble bus as seen at the pins |
| busOut | output | 4 | Nibble the target drives when enabled |
| busOe | output | 1 | High while the target drives the nibble bus |
| idStrap | input | 4 | Strapped device identity compared with the select nibble |
| memAddr | output | ADDR_W | Memory read address (low bits of the bus address) |
| memRdEn | output | 1 | One-clock memory read request |
| memRdData | input | 8 | Read data, valid the clock after `memRdEn` |

## Verification
The checker watches the shape of the drive window on every cycle. The window may never last longer than four clocks. It must always open with the ready sync, always close on an all-ones nibble, and always follow a single-clock read strobe issued two clocks earlier. Reset must keep the bus released. What the checker cannot see is whether a window should have opened at all. That covers the start-field rule under a long strobe, the ID compare, the size check and the nibble order and value of the returned byte. These only the bench's scenarios show, by comparing each clock of a transaction with a model of the memory contents.

// File: rtl/fwh_pkg.sv
package fwh_pkg;

  localparam logic [3:0] START_CODE = 4'b1101;
  localparam logic [3:0] SYNC_READY = 4'b0000;
  localparam logic [3:0] SIZE_ONE   = 4'b0000;
  localparam logic [3:0] NIB_ONES   = 4'b1111;
  localparam int         ADDR_NIBS  = 7;
  localparam int         CNT_W      = $clog2(ADDR_NIBS);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL,
    ST_ADDR,
    ST_SIZE,
    ST_HTAR,
    ST_FLOAT,
    ST_SYNC,
    ST_DLO,
    ST_DHI,
    ST_TTAR
  } fwhState_e;

  typedef enum logic [2:0] {
    DRV_OFF,
    DRV_SYNC,
    DRV_LO,
    DRV_HI,
    DRV_ONES
  } drvSel_e;

  typedef struct packed {
    logic    shiftAddr;
    logic    readMem;
    logic    loadData;
    drvSel_e drv;
  } fwhStrobe_t;

endpackage

// File: rtl/fwh_ctrl.sv
module fwh_ctrl
  import fwh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic [3:0] busIn,
  input  logic [3:0] idStrap,
  output fwhStrobe_t strobe
);

  fwhState_e        state, stateNxt;
  logic [CNT_W-1:0] nibCnt, nibCntNxt;

  logic startSeen;
  assign startSeen = !frameN && (busIn == START_CODE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      nibCnt <= '0;
    end else begin
      state  <= stateNxt;
      nibCnt <= nibCntNxt;
    end
  end

  always_comb begin
    stateNxt  = state;
    nibCntNxt = nibCnt;
    strobe    = '{shiftAddr: 1'b0, readMem: 1'b0, loadData: 1'b0, drv: DRV_OFF};
    unique case (state)
      ST_IDLE: begin
        if (startSeen) stateNxt = ST_SEL;
      end
      ST_SEL: begin
        if (!frameN) begin
          // strobe still low: only the final low-strobe nibble counts
          if (!startSeen) stateNxt = ST_IDLE;
        end else if (busIn == idStrap) begin
          stateNxt  = ST_ADDR;
          nibCntNxt = '0;
        end else begin
          stateNxt = ST_IDLE;
        end
      end
      ST_ADDR: begin
        strobe.shiftAddr = 1'b1;
        if (nibCnt == CNT_W'(ADDR_NIBS - 1)) stateNxt = ST_SIZE;
        else nibCntNxt = nibCnt + 1'b1;
      end
      ST_SIZE: begin
        stateNxt = (busIn == SIZE_ONE) ? ST_HTAR : ST_IDLE;
      end
      ST_HTAR: begin
        strobe.readMem = 1'b1;
        stateNxt       = ST_FLOAT;
      end
      ST_FLOAT: begin
        strobe.loadData = 1'b1;
        stateNxt        = ST_SYNC;
      end
      ST_SYNC: begin
        strobe.drv = DRV_SYNC;
        stateNxt   = ST_DLO;
      end
      ST_DLO: begin
        strobe.drv = DRV_LO;
        stateNxt   = ST_DHI;
      end
      ST_DHI: begin
        strobe.drv = DRV_HI;
        stateNxt   = ST_TTAR;
      end
      ST_TTAR: begin
        strobe.drv = DRV_ONES;
        stateNxt   = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/fwh_dpath.sv
module fwh_dpath
  import fwh_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        busIn,
  input  fwhStrobe_t        strobe,
  input  logic [7:0]        memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  output logic [3:0]        busOut,
  output logic              busOe
);

  logic [ADDR_W-1:0] addrShift;
  logic [7:0]        dataReg;

  // only the low ADDR_W bits are kept; upper nibbles shift out
  generate
    if (ADDR_W > 4) begin : g_wide
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 addrShift <= '0;
        else if (strobe.shiftAddr) addrShift <= {addrShift[ADDR_W-5:0], busIn};
      end
    end else begin : g_narrow
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 addrShift <= '0;
        else if (strobe.shiftAddr) addrShift <= busIn[ADDR_W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dataReg <= '0;
    else if (strobe.loadData) dataReg <= memRdData;
  end

  assign memAddr = addrShift;
  assign memRdEn = strobe.readMem;
  assign busOe   = (strobe.drv != DRV_OFF);

  always_comb begin
    unique case (strobe.drv)
      DRV_SYNC: busOut = SYNC_READY;
      DRV_LO:   busOut = dataReg[3:0];
      DRV_HI:   busOut = dataReg[7:4];
      default:  busOut = NIB_ONES;
    endcase
  end

endmodule

// File: rtl/fwh_read_target.sv
module fwh_read_target
  import fwh_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameN,
  input  logic [3:0]        busIn,
  output logic [3:0]        busOut,
  output logic              busOe,
  input  logic [3:0]        idStrap,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  input  logic [7:0]        memRdData
);

  fwhStrobe_t strobe;

  fwh_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .frameN  (frameN),
    .busIn   (busIn),
    .idStrap (idStrap),
    .strobe  (strobe)
  );

  fwh_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .busIn     (busIn),
    .strobe    (strobe),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memRdEn   (memRdEn),
    .busOut    (busOut),
    .busOe     (busOe)
  );

endmodule

// File: rtl/fwh_read_target_chk.sv
module fwh_read_target_chk (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] busOut,
  input logic       busOe,
  input logic       memRdEn
);

  logic [2:0] oeRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      oeRun <= '0;
    else if (busOe) oeRun <= (oeRun == 3'd7) ? oeRun : oeRun + 3'd1;
    else            oeRun <= '0;
  end

  AST_RESET_RELEASE: assert property (@(posedge clk) !rstN |-> (!busOe && !memRdEn)); // R10
  AST_SYNC_OPENS: assert property (@(posedge clk) disable iff (!rstN) $rose(busOe) |-> busOut == 4'b0000); // R7
  AST_READ_LEADS: assert property (@(posedge clk) disable iff (!rstN) $rose(busOe) |-> $past(memRdEn, 2)); // R5
  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rstN) memRdEn |=> !memRdEn); // R5
  AST_OE_SPAN: assert property (@(posedge clk) disable iff (!rstN) busOe |-> oeRun < 3'd4); // R9
  AST_ONES_CLOSE: assert property (@(posedge clk) disable iff (!rstN) $fell(busOe) |-> $past(busOut) == 4'b1111); // R9

endmodule

bind fwh_read_target fwh_read_target_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busOut  (busOut),
  .busOe   (busOe),
  .memRdEn (memRdEn)
);

// File: tb/fwh_read_target_bench.sv
module fwh_read_target_bench;

  localparam int         ADDR_W = 20;
  localparam logic [3:0] MY_ID  = 4'h3;

  logic              clk = 1'b0;
  logic              rstN;
  logic              frameN;
  logic [3:0]        busIn;
  logic [3:0]        busOut;
  logic              busOe;
  logic [3:0]        idStrap;
  logic [ADDR_W-1:0] memAddr;
  logic              memRdEn;
  logic [7:0]        memRdData;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  fwh_read_target #(.ADDR_W(ADDR_W)) u_fwh_read_target (
    .clk       (clk),
    .rstN      (rstN),
    .frameN    (frameN),
    .busIn     (busIn),
    .busOut    (busOut),
    .busOe     (busOe),
    .idStrap   (idStrap),
    .memAddr   (memAddr),
    .memRdEn   (memRdEn),
    .memRdData (memRdData)
  );

  function automatic logic [7:0] memFn(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (memRdEn) memRdData <= memFn(memAddr);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic fr, input logic [3:0] nib);
    @(negedge clk);
    frameN = fr;
    busIn  = nib;
  endtask

  // one full 17-clock window; clock k is sampled just before its edge
  task automatic runCycle(input string req, input int preStarts,
                          input logic [3:0] lastStart, input logic [3:0] sel,
                          input logic [27:0] addr, input logic [3:0] size);
    logic       resp;
    logic [7:0] d;
    resp = (lastStart == 4'hD) && (sel == MY_ID) && (size == 4'h0);
    d    = memFn(addr[ADDR_W-1:0]);
    for (int i = 0; i < preStarts; i++) begin
      step(1'b0, 4'hD);
      check(!busOe, req, "oe during long strobe", busOe, 0);
    end
    step(1'b0, lastStart);                                    // clock 1
    check(!busOe, req, "oe clk1", busOe, 0);
    step(1'b1, sel);                                          // clock 2
    for (int i = 0; i < 7; i++) begin                         // clocks 3..9
      step(1'b1, addr[27-4*i -: 4]);
      check(!busOe, req, "oe addr", busOe, 0);
    end
    step(1'b1, size);                                         // clock 10
    check(!memRdEn, {req, " R5"}, "early read", memRdEn, 0);
    step(1'b1, 4'hF);                                         // clock 11
    check(memRdEn == resp, {req, " R5 R6"}, "read strobe clk11", memRdEn, resp);
    if (resp) check(memAddr == addr[ADDR_W-1:0], "R4", "memAddr", memAddr, addr[ADDR_W-1:0]);
    check(!busOe, "R7", "oe clk11", busOe, 0);
    step(1'b1, 4'hF);                                         // clock 12
    check(!memRdEn, "R5", "read clk12", memRdEn, 0);
    check(!busOe, "R7", "oe clk12", busOe, 0);
    step(1'b1, 4'hF);                                         // clock 13
    check(busOe == resp, {req, " R7"}, "oe sync", busOe, resp);
    if (resp) check(busOut == 4'h0, "R7", "sync nibble", busOut, 0);
    step(1'b1, 4'hF);                                         // clock 14
    check(busOe == resp, {req, " R8"}, "oe lo", busOe, resp);
    if (resp) check(busOut == d[3:0], "R8", "low nibble", busOut, d[3:0]);
    step(1'b1, 4'hF);                                         // clock 15
    check(busOe == resp, {req, " R8"}, "oe hi", busOe, resp);
    if (resp) check(busOut == d[7:4], "R8", "high nibble", busOut, d[7:4]);
    step(1'b1, 4'hF);                                         // clock 16
    check(busOe == resp, {req, " R9"}, "oe ones", busOe, resp);
    if (resp) check(busOut == 4'hF, "R9", "ones nibble", busOut, 4'hF);
    step(1'b1, 4'hF);                                         // clock 17
    check(!busOe, "R9", "oe released", busOe, 0);
    check(!memRdEn, "R9", "read clk17", memRdEn, 0);
  endtask

  task automatic testReset();
    check(!busOe && !memRdEn, "R10", "reset state", {busOe, memRdEn}, 0);
  endtask

  task automatic testNoStart();
    step(1'b1, 4'hD);
    for (int i = 0; i < 4; i++) begin
      step(1'b1, MY_ID);
      check(!busOe && !memRdEn, "R1", "high strobe start", busOe, 0);
    end
    runCycle("R1", 0, 4'hA, MY_ID, 28'h0000123, 4'h0);
  endtask

  task automatic testResetMid();
    step(1'b0, 4'hD);
    step(1'b1, MY_ID);
    for (int i = 0; i < 7; i++) step(1'b1, 4'h2);
    step(1'b1, 4'h0);
    step(1'b1, 4'hF);
    step(1'b1, 4'hF);
    step(1'b1, 4'hF);                                         // clock 13
    check(busOe, "R10", "oe before reset", busOe, 1);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(!busOe && !memRdEn, "R10", "mid reset release", busOe, 0);
    rstN = 1'b1;
    step(1'b1, 4'hF);
    check(!busOe, "R10", "idle after reset", busOe, 0);
  endtask

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN    = 1'b0;
    frameN  = 1'b1;
    busIn   = 4'hF;
    idStrap = MY_ID;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    step(1'b1, 4'hF);
    runCycle("R1 R4", 0, 4'hD, MY_ID, 28'hABC1234, 4'h0);
    runCycle("R11", 0, 4'hD, MY_ID, 28'h00F5A69, 4'h0);        // back to back
    runCycle("R3", 0, 4'hD, 4'h5, 28'h0012345, 4'h0);
    runCycle("R6", 0, 4'hD, MY_ID, 28'h0012345, 4'h1);
    runCycle("R2", 3, 4'hD, MY_ID, 28'hFFE7C30, 4'h0);
    runCycle("R2", 2, 4'h0, MY_ID, 28'h0054321, 4'h0);
    testNoStart();
    testResetMid();
    runCycle("R10 R4", 0, 4'hD, MY_ID, 28'h00FFFFF, 4'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule